// File: doc/BRIEF.md
# Host-Paced Boot Word Receiver

This block takes a boot stream from a slow external host over a parallel data bus. The host paces the transfers with an active-low request line, and the block answers on an acknowledge output. The request is asynchronous to the block clock. It passes through a two-flop synchroniser, and a transfer starts only on a falling edge of the synchronised request. On that edge the block samples the bus and raises the acknowledge. It holds the acknowledge high until the host has released the request and a fixed turnaround delay has run out. While the acknowledge is low, the block is ready for the next transfer.

The first handshake after reset, or after a restart, asks to enter the mode, and its data is discarded. The next transfer carries the width keyword. The word 10AAh selects 16-bit transfers. The low byte 08h followed by the low byte AAh selects 8-bit transfers. Any other value makes the block pulse a reject output and wait for a new entry handshake. After the keyword is accepted, every complete table word goes downstream on a one-cycle write strobe. In 16-bit mode one transfer makes one word. In 8-bit mode two transfers make one word, high byte first, taken from the low eight data lines. The write strobe always comes a set number of cycles after the acknowledge rises. A bus-drive enable is high only inside the acknowledge window.

An idle counter reports that no host is present when no request has arrived within a programmable number of cycles after reset.

Top module: `handshake_boot_rx`

## Requirements
- R1: After reset, ackOut, busDriveEn, wordValid, kwReject and noHost are all 0.
- R2: When hostReqN falls while ackOut is low, hostData is captured and ackOut rises on the third rising clock edge after the new level is present at the input.
- R3: ackOut stays high while hostReqN is low. It falls on edge max(h+3, STROBE_DELAY+1) after its rise, where h is the number of cycles after the rise at which the host raises hostReqN. A new capture needs a new falling edge.
- R4: The first transfer after reset or after a reject is the entry handshake. Its data is ignored, and it produces no wordValid and no kwReject.
- R5: A keyword transfer of 16'h10AA selects 16-bit mode. Each later transfer gives one wordValid, with wordData equal to the full 16-bit bus value.
- R6: A keyword of low byte 8'h08 followed by a transfer with low byte 8'hAA selects 8-bit mode, and bits 15:8 are ignored. In this mode the first transfer of each pair supplies wordData[15:8], the second supplies wordData[7:0], and only the second produces wordValid.
- R7: Any other keyword value, in either keyword transfer, makes kwReject high for exactly one cycle, on the same edge where ackOut rises. The block then expects a new entry handshake.
- R8: wordValid is a one-cycle pulse. It rises exactly STROBE_DELAY cycles after the ackOut rise of the transfer that completed the word. STROBE_DELAY is forced to at least 10.
- R9: busDriveEn rises one cycle after ackOut rises and falls on the same edge as ackOut. It is never high while ackOut is low.
- R10: With a non-zero noHostLimit, noHost goes high after noHostLimit clock edges without any request since reset. A noHostLimit of 0 disables the report, and noHost clears on the first captured request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReqN | input | 1 | Active-low request from the host, asynchronous |
| hostData | input | DATA_W | Parallel data bus from the host |
| noHostLimit | input | TO_W | Idle cycles before noHost is raised; 0 disables |
| ackOut | output | 1 | Acknowledge to the host; low means ready |
| busDriveEn | output | 1 | Enable for the external bus drivers |
| wordValid | output | 1 | One-cycle write strobe for an assembled word |
| wordData | output | DATA_W | Assembled table word |
| kwReject | output | 1 | One-cycle pulse on an invalid keyword |
| noHost | output | 1 | No request seen within the idle limit |

## Verification
The acknowledge is due on the third rising edge after the request falls. The reject pulse comes on that same edge. The write strobe comes STROBE_DELAY edges later, and the acknowledge falls on edge max(h+3, STROBE_DELAY+1), where h is when the host released the request. The bench changes its inputs and samples the outputs on falling clock edges. For each transfer it counts falling edges from the first one that shows the acknowledge high, and it compares the index where the strobe, the reject and the acknowledge fall appear against these formulas, not just their presence. The idle report is checked one edge before and exactly at the programmed limit.

// File: rtl/hsrx_pkg.sv
package hsrx_pkg;

  localparam logic [15:0] KEY_WIDE      = 16'h10AA;
  localparam logic [7:0]  KEY_NARROW_HI = 8'h08;
  localparam logic [7:0]  KEY_NARROW_LO = 8'hAA;
  localparam int          MIN_TURN      = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic capWide;   // load whole bus into the word register
    logic capHi;     // load low byte into the high-byte holder
    logic capLo;     // join held byte and low byte into the word register
  } dpStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic reqFall;
    logic reqHigh;
    logic isWideKey;
    logic isNarrowHi;
    logic isNarrowLo;
  } dpStatus_t;

  typedef enum logic [2:0] {
    PH_ENTRY,
    PH_KEY,
    PH_KEY_LO,
    PH_WIDE,
    PH_NARROW_HI,
    PH_NARROW_LO
  } phase_t;

endpackage

// File: rtl/hsrx_datapath.sv
module hsrx_datapath
  import hsrx_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReqN,
  input  logic [DATA_W-1:0] hostData,
  input  dpStrobe_t         dpCtl,
  output dpStatus_t         dpStat,
  output logic [DATA_W-1:0] wordData
);

  localparam int BYTE_W = DATA_W / 2;

  logic              reqMeta, reqSync, reqPrev;
  logic [BYTE_W-1:0] hiByteQ;
  logic [DATA_W-1:0] wordQ;

  // two-flop synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqMeta <= 1'b1;
      reqSync <= 1'b1;
      reqPrev <= 1'b1;
    end else begin
      reqMeta <= hostReqN;
      reqSync <= reqMeta;
      reqPrev <= reqSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiByteQ <= '0;
      wordQ   <= '0;
    end else begin
      if (dpCtl.capHi)   hiByteQ <= hostData[BYTE_W-1:0];
      if (dpCtl.capWide) wordQ   <= hostData;
      else if (dpCtl.capLo) wordQ <= {hiByteQ, hostData[BYTE_W-1:0]};
    end
  end

  always_comb begin
    dpStat.reqFall    = reqPrev & ~reqSync;
    dpStat.reqHigh    = reqSync;
    dpStat.isWideKey  = (hostData == DATA_W'(KEY_WIDE));
    dpStat.isNarrowHi = (hostData[BYTE_W-1:0] == BYTE_W'(KEY_NARROW_HI));
    dpStat.isNarrowLo = (hostData[BYTE_W-1:0] == BYTE_W'(KEY_NARROW_LO));
  end

  assign wordData = wordQ;

endmodule

// File: rtl/hsrx_control.sv
module hsrx_control
  import hsrx_pkg::*;
#(
  parameter int STROBE_DELAY = 10,
  parameter bit TIMEOUT_EN   = 1'b1,
  parameter int TO_W         = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStatus_t       dpStat,
  input  logic [TO_W-1:0] noHostLimit,
  output dpStrobe_t       dpCtl,
  output logic            ackOut,
  output logic            busDriveEn,
  output logic            wordValid,
  output logic            kwReject,
  output logic            noHost
);

  localparam int DLY_EFF = (STROBE_DELAY < MIN_TURN) ? MIN_TURN : STROBE_DELAY;
  localparam int CNT_W   = $clog2(DLY_EFF + 2);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(DLY_EFF);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(DLY_EFF - 1);

  phase_t           phaseQ, phaseD;
  logic             holdQ, busEnQ, emitQ, validQ, rejectQ;
  logic [CNT_W-1:0] cntQ;
  logic             capture, delayDone, releaseAck, wordDone, rejectD;

  assign capture    = !holdQ && dpStat.reqFall;
  assign delayDone  = (cntQ == CNT_DONE);
  assign releaseAck = holdQ && delayDone && dpStat.reqHigh;

  always_comb begin
    dpCtl    = '0;
    phaseD   = phaseQ;
    rejectD  = 1'b0;
    wordDone = 1'b0;
    if (capture) begin
      unique case (phaseQ)
        PH_ENTRY: phaseD = PH_KEY;
        PH_KEY: begin
          if (dpStat.isWideKey)       phaseD = PH_WIDE;
          else if (dpStat.isNarrowHi) phaseD = PH_KEY_LO;
          else begin
            phaseD  = PH_ENTRY;
            rejectD = 1'b1;
          end
        end
        PH_KEY_LO: begin
          if (dpStat.isNarrowLo) phaseD = PH_NARROW_HI;
          else begin
            phaseD  = PH_ENTRY;
            rejectD = 1'b1;
          end
        end
        PH_WIDE: begin
          dpCtl.capWide = 1'b1;
          wordDone      = 1'b1;
        end
        PH_NARROW_HI: begin
          dpCtl.capHi = 1'b1;
          phaseD      = PH_NARROW_LO;
        end
        PH_NARROW_LO: begin
          dpCtl.capLo = 1'b1;
          wordDone    = 1'b1;
          phaseD      = PH_NARROW_HI;
        end
        default: phaseD = PH_ENTRY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_ENTRY;
      holdQ   <= 1'b0;
      busEnQ  <= 1'b0;
      cntQ    <= '0;
      emitQ   <= 1'b0;
      validQ  <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      phaseQ  <= phaseD;
      rejectQ <= rejectD;
      busEnQ  <= holdQ && !releaseAck;
      validQ  <= holdQ && emitQ && (cntQ == CNT_FIRE);
      if (capture)         holdQ <= 1'b1;
      else if (releaseAck) holdQ <= 1'b0;
      if (capture)                 cntQ <= '0;
      else if (holdQ && !delayDone) cntQ <= cntQ + 1'b1;
      if (capture)                                   emitQ <= wordDone;
      else if (holdQ && emitQ && (cntQ == CNT_FIRE)) emitQ <= 1'b0;
    end
  end

  assign ackOut     = holdQ;
  assign busDriveEn = busEnQ;
  assign wordValid  = validQ;
  assign kwReject   = rejectQ;

  generate
    if (TIMEOUT_EN) begin : g_idle
      logic [TO_W-1:0] idleQ;
      logic            seenQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          idleQ <= '0;
          seenQ <= 1'b0;
        end else begin
          if (capture) seenQ <= 1'b1;
          if (!seenQ && idleQ != noHostLimit) idleQ <= idleQ + 1'b1;
        end
      end
      assign noHost = !seenQ && (noHostLimit != '0) && (idleQ == noHostLimit);
    end else begin : g_no_idle
      assign noHost = 1'b0 & (|noHostLimit);
    end
  endgenerate

endmodule

// File: rtl/handshake_boot_rx.sv
module handshake_boot_rx
  import hsrx_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int STROBE_DELAY = 10,
  parameter bit TIMEOUT_EN   = 1'b1,
  parameter int TO_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReqN,
  input  logic [DATA_W-1:0] hostData,
  input  logic [TO_W-1:0]   noHostLimit,
  output logic              ackOut,
  output logic              busDriveEn,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              kwReject,
  output logic              noHost
);

  dpStrobe_t dpCtl;
  dpStatus_t dpStat;

  hsrx_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .hostReqN (hostReqN),
    .hostData (hostData),
    .dpCtl    (dpCtl),
    .dpStat   (dpStat),
    .wordData (wordData)
  );

  hsrx_control #(
    .STROBE_DELAY (STROBE_DELAY),
    .TIMEOUT_EN   (TIMEOUT_EN),
    .TO_W         (TO_W)
  ) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .dpStat      (dpStat),
    .noHostLimit (noHostLimit),
    .dpCtl       (dpCtl),
    .ackOut      (ackOut),
    .busDriveEn  (busDriveEn),
    .wordValid   (wordValid),
    .kwReject    (kwReject),
    .noHost      (noHost)
  );

endmodule

// File: rtl/handshake_boot_rx_chk.sv
module handshake_boot_rx_chk #(
  parameter int STROBE_DELAY = 10
) (
  input logic clk,
  input logic rstN,
  input logic hostReqN,
  input logic ackOut,
  input logic busDriveEn,
  input logic wordValid,
  input logic kwReject,
  input logic noHost
);

  localparam int DLY_EFF = (STROBE_DELAY < 10) ? 10 : STROBE_DELAY;
  localparam int CNT_W   = $clog2(DLY_EFF + 3);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(DLY_EFF + 2);

  logic [CNT_W-1:0] sinceAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceAck <= '0;
    else if (!ackOut)         sinceAck <= '0;
    else if (sinceAck != SAT) sinceAck <= sinceAck + 1'b1;
  end

  // R9
  bus_en_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDriveEn |-> ackOut);

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R8
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (sinceAck == CNT_W'(DLY_EFF)));

  // R3
  ack_turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackOut) |-> (sinceAck > CNT_W'(DLY_EFF)));

  // R2
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> !$past(hostReqN, 3));

  // R7
  reject_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    kwReject |=> !kwReject);

  // R7
  reject_with_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    kwReject |-> $rose(ackOut));

  // R10
  no_host_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    noHost |-> !ackOut);

endmodule

bind handshake_boot_rx handshake_boot_rx_chk #(.STROBE_DELAY(STROBE_DELAY)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostReqN   (hostReqN),
  .ackOut     (ackOut),
  .busDriveEn (busDriveEn),
  .wordValid  (wordValid),
  .kwReject   (kwReject),
  .noHost     (noHost)
);

// File: tb/test_handshake_boot_rx.sv
module test_handshake_boot_rx;

  localparam int DLY      = 10;
  localparam int NVEC     = 19;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReqN = 1'b1;
  logic [15:0] hostData = '0;
  logic [15:0] noHostLimit = 16'd1000;
  logic        ackOut, busDriveEn, wordValid, kwReject, noHost;
  logic [15:0] wordData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  handshake_boot_rx i_handshake_boot_rx (
    .clk         (clk),
    .rstN        (rstN),
    .hostReqN    (hostReqN),
    .hostData    (hostData),
    .noHostLimit (noHostLimit),
    .ackOut      (ackOut),
    .busDriveEn  (busDriveEn),
    .wordValid   (wordValid),
    .wordData    (wordData),
    .kwReject    (kwReject),
    .noHost      (noHost)
  );

  // {reset, hold, data, expStrobe, expWord, expReject}
  localparam logic [42:0] VEC [0:NVEC-1] = '{
    {1'b1, 8'd2,  16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h10AA, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h1234, 1'b1, 16'h1234, 1'b0},
    {1'b0, 8'd20, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0},
    {1'b1, 8'd2,  16'h5555, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h7708, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h12AA, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h33BE, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd20, 16'h00EF, 1'b1, 16'hBEEF, 1'b0},
    {1'b0, 8'd2,  16'h0001, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'hFF02, 1'b1, 16'h0102, 1'b0},
    {1'b1, 8'd2,  16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h1234, 1'b0, 16'h0000, 1'b1},
    {1'b0, 8'd2,  16'h9999, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h0008, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h0055, 1'b0, 16'h0000, 1'b1},
    {1'b0, 8'd2,  16'h0000, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'h10AA, 1'b0, 16'h0000, 1'b0},
    {1'b0, 8'd2,  16'hCAFE, 1'b1, 16'hCAFE, 1'b0}
  };

  localparam string TAGS [0:NVEC-1] = '{
    "R4", "R5", "R5", "R5", "R4", "R6", "R6", "R6", "R6", "R6",
    "R6", "R4", "R7", "R4", "R6", "R7", "R4", "R5", "R5"
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    hostReqN = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic xfer(input string tag, input logic [15:0] data, input int hold,
                      input bit expStrobe, input logic [15:0] expWord, input bit expRej);
    int lat, fallIdx, strobes, strobeIdx, rejs, rejIdx, expFall;
    logic [15:0] gotWord;
    logic busEn0, busEn1, ackMid;
    lat = 0; fallIdx = -1; strobes = 0; strobeIdx = -1; rejs = 0; rejIdx = -1;
    gotWord = '0; busEn0 = 1'b1; busEn1 = 1'b0; ackMid = 1'b1;
    hostData = data;
    hostReqN = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      lat++;
      if (ackOut) break;
    end
    // R2: ack due on third rising edge after the request falls
    chk("R2", "ack rise latency", lat, 3);
    for (int k = 0; k < 200; k++) begin
      if (!ackOut) begin
        fallIdx = k;
        break;
      end
      if (wordValid) begin
        strobes++;
        strobeIdx = k;
        gotWord = wordData;
      end
      if (kwReject) begin
        rejs++;
        rejIdx = k;
      end
      if (k == 0) busEn0 = busDriveEn;
      if (k == 1) busEn1 = busDriveEn;
      if (k == hold - 1) ackMid = ackOut;
      if (k == hold) begin
        hostReqN = 1'b1;
        hostData = ~data;
      end
      @(negedge clk);
    end
    expFall = (hold + 3 > DLY + 1) ? hold + 3 : DLY + 1;
    chk("R3", "ack fall index", fallIdx, expFall);
    if (hold > DLY + 1) chk("R3", "ack held while request low", ackMid, 1);
    chk("R9", "busDriveEn on ack rise", busEn0, 0);
    chk("R9", "busDriveEn one cycle later", busEn1, 1);
    chk("R9", "busDriveEn after ack fall", busDriveEn, 0);
    chk(tag, "strobe count", strobes, expStrobe);
    if (expStrobe) begin
      chk("R8", "strobe index after ack rise", strobeIdx, DLY);
      chk(tag, "assembled word", gotWord, expWord);
    end
    chk(tag, "reject count", rejs, expRej);
    if (expRej) chk("R7", "reject index", rejIdx, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    noHostLimit = 16'd20;
    doReset();
    @(negedge clk);
    chk("R1", "ackOut after reset", ackOut, 0);
    chk("R1", "busDriveEn after reset", busDriveEn, 0);
    chk("R1", "wordValid after reset", wordValid, 0);
    chk("R1", "kwReject after reset", kwReject, 0);
    chk("R1", "noHost after reset", noHost, 0);

    // R10: idle report at exactly the programmed limit
    doReset();
    repeat (19) @(negedge clk);
    chk("R10", "noHost one edge before limit", noHost, 0);
    @(negedge clk);
    chk("R10", "noHost at limit", noHost, 1);
    repeat (5) @(negedge clk);
    chk("R10", "noHost stays set", noHost, 1);
    xfer("R4", 16'hABCD, 2, 1'b0, 16'h0000, 1'b0);
    chk("R10", "noHost cleared by request", noHost, 0);
    noHostLimit = 16'd0;
    doReset();
    repeat (40) @(negedge clk);
    chk("R10", "zero limit disables report", noHost, 0);
    noHostLimit = 16'd1000;

    // table-driven sessions
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][42]) doReset();
      xfer(TAGS[i], VEC[i][33:18], int'(VEC[i][41:34]), VEC[i][17], VEC[i][16:1], VEC[i][0]);
    end

    // R3: a request held low across the whole window gives a single capture
    doReset();
    xfer("R4", 16'h0000, 2, 1'b0, 16'h0000, 1'b0);
    xfer("R5", 16'h10AA, 2, 1'b0, 16'h0000, 1'b0);
    xfer("R5", 16'h2468, 40, 1'b1, 16'h2468, 1'b0);
    repeat (10) @(negedge clk);
    chk("R3", "no extra capture while idle", ackOut, 0);
    chk("R3", "no extra strobe while idle", wordValid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule